// File: doc/BRIEF.md
# Serial Memory Command Controller

This block is the instruction layer of a small serial memory. A character framer hands it received bytes, each with a flag that marks a parity failure. The block collects an opcode and any address and data bytes that follow it. It writes into a synchronous byte RAM, streams bytes back from a start address, and answers a status query. Outgoing bytes are offered to the framer under a valid/ready handshake, together with an even parity bit. It also raises a drive-enable signal that the pad logic uses to float the serial output.

Chip select works as a soft reset. Taking it low ends any command or stream and floats the output. It does not clear the error flags and it does not cut short a program cycle. When an unknown opcode or a parity failure arrives, the block goes silent and ignores everything until chip select is pulsed low. A status read issued after that pulse reports the cause, and the status read then clears the flags. A program cycle holds a busy state for a set number of clocks. During that time only the status query is acted upon.

Top module: `sercmd_ctrl`

## Requirements
- R1: After reset and while chip select is high with no error pending, `out_drive` is 1 and no byte is offered. While chip select is low, `out_drive` and `tx_valid` are 0.
- R2: Opcode 8'h3C returns one status byte. Bits 7:5 are 3'b101, bit 4 is the parity-error flag, bit 3 is the instruction-error flag, bit 2 is busy, and bits 1:0 are 0. An idle, error-free block returns 8'hA0.
- R3: Opcode 8'hA3, then a high address byte, then a low address byte, starts a stream. The start address is the low ADDR_W bits of {high, low}. The stream returns the stored bytes at ascending addresses, each byte exactly once, and holds each byte stable until `tx_ready`.
- R4: The stream ends after address 2^ADDR_W-1 and does not wrap around. No further byte is offered after that.
- R5: Taking chip select low during a stream ends it at once. No byte of the interrupted stream is offered afterwards.
- R6: When `par_en` is 1, `tx_par` is the even parity of `tx_data`, so that data plus parity holds an even number of ones. When `par_en` is 0, `tx_par` is 0.
- R7: An opcode other than 8'h3C, 8'hA3 or 8'h5A sets the instruction-error flag and mutes the block. While muted, `out_drive` is 0, no byte is offered, and every received byte is ignored (including parity failures and status queries) until chip select goes low.
- R8: A byte received with `rx_perr` set, while an opcode, address or data byte is expected, sets the parity-error flag and mutes the block as in R7. A data byte received this way is not written.
- R9: The error flags survive the chip-select pulse. A status read issued after the pulse reports them, and that read clears them, so the next status read returns 8'hA0.
- R10: Opcode 8'h5A, then high address, low address and a data byte, stores the data byte and starts a busy period of BUSY_CYC clocks. A status read during that period returns 8'hA4. A status read after it returns 8'hA0.
- R11: During the busy period, any opcode other than 8'h3C is dropped. It sets no error flag and starts no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select; low ends activity and floats the output |
| par_en | input | 1 | Enables the outgoing parity bit |
| rx_valid | input | 1 | A received byte is present for one clock |
| rx_data | input | 8 | Received byte |
| rx_perr | input | 1 | The received byte failed its parity check |
| tx_ready | input | 1 | The framer accepts the offered byte |
| tx_valid | output | 1 | A byte is offered |
| tx_data | output | 8 | Offered byte |
| tx_par | output | 1 | Even parity of the offered byte when enabled |
| out_drive | output | 1 | Serial output is driven (0 means floated) |

## Verification
The bench streams from near the top of memory under irregular `tx_ready`. A design that wrapped or stopped one address early would offer a byte the model does not expect, or leave expected bytes undelivered. Chip select is dropped in the middle of a stream: a controller that kept its pending byte would offer it after reselection. While muted, the bench feeds in parity failures and status queries. A design that listened while muted would talk, or would report an extra flag after the pulse. Other checks cover a flag cleared too early or too late, and a busy window off by a cycle.

// File: rtl/sercmd_ctrl.sv
module sercmd_ctrl #(
  parameter int          ADDR_W   = 9,
  parameter int          BUSY_CYC = 4000,
  parameter logic [7:0]  OP_STAT  = 8'h3C,
  parameter logic [7:0]  OP_RSEQ  = 8'hA3,
  parameter logic [7:0]  OP_WRITE = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       par_en,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_perr,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_par,
  output logic       out_drive
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
  localparam int CW = $clog2(BUSY_CYC + 1);

  typedef enum logic [2:0] {
    S_OP, S_AHI, S_ALO, S_WDAT, S_RREQ, S_RLOAD, S_SEND, S_MUTE
  } state_t;

  state_t            st;
  logic [7:0]        mem [DEPTH];
  logic [7:0]        mem_q, a_hi, tx_buf;
  logic [ADDR_W-1:0] addr;
  logic [CW-1:0]     busy_cnt;
  logic              perr_f, ierr_f, is_wr, streaming, tx_v;
  logic              busy, take, bad, we;
  logic [15:0]       full_a;

  assign busy      = |busy_cnt;
  assign take      = cs && rx_valid;
  assign bad       = rx_perr;
  assign full_a    = {a_hi, rx_data};
  assign we        = take && !bad && st == S_WDAT;
  assign tx_valid  = tx_v && cs;
  assign tx_data   = tx_buf;
  assign tx_par    = par_en & ^tx_buf;
  assign out_drive = cs && st != S_MUTE;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= rx_data;
    mem_q <= mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_OP;
      perr_f    <= 1'b0;
      ierr_f    <= 1'b0;
      is_wr     <= 1'b0;
      streaming <= 1'b0;
      tx_v      <= 1'b0;
      tx_buf    <= '0;
      a_hi      <= '0;
      addr      <= '0;
      busy_cnt  <= '0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (!cs) begin
        st   <= S_OP;
        tx_v <= 1'b0;
      end else begin
        case (st)
          S_OP: if (take) begin
            if (bad) begin
              perr_f <= 1'b1;
              st     <= S_MUTE;
            end else if (rx_data == OP_STAT) begin
              tx_buf    <= {3'b101, perr_f, ierr_f, busy, 2'b00};
              perr_f    <= 1'b0;
              ierr_f    <= 1'b0;
              tx_v      <= 1'b1;
              streaming <= 1'b0;
              st        <= S_SEND;
            end else if (busy) begin
              st <= S_OP;
            end else if (rx_data == OP_RSEQ || rx_data == OP_WRITE) begin
              is_wr <= (rx_data == OP_WRITE);
              st    <= S_AHI;
            end else begin
              ierr_f <= 1'b1;
              st     <= S_MUTE;
            end
          end
          S_AHI: if (take) begin
            if (bad) begin
              perr_f <= 1'b1;
              st     <= S_MUTE;
            end else begin
              a_hi <= rx_data;
              st   <= S_ALO;
            end
          end
          S_ALO: if (take) begin
            if (bad) begin
              perr_f <= 1'b1;
              st     <= S_MUTE;
            end else begin
              addr <= full_a[ADDR_W-1:0];
              st   <= is_wr ? S_WDAT : S_RREQ;
            end
          end
          S_WDAT: if (take) begin
            if (bad) begin
              perr_f <= 1'b1;
              st     <= S_MUTE;
            end else begin
              busy_cnt <= CW'(BUSY_CYC);
              st       <= S_OP;
            end
          end
          S_RREQ:  st <= S_RLOAD;
          S_RLOAD: begin
            tx_buf    <= mem_q;
            tx_v      <= 1'b1;
            streaming <= 1'b1;
            st        <= S_SEND;
          end
          S_SEND: if (tx_ready) begin
            tx_v <= 1'b0;
            if (streaming && addr != LAST) begin
              addr <= addr + 1'b1;
              st   <= S_RREQ;
            end else begin
              st <= S_OP;
            end
          end
          default: st <= S_MUTE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sercmd_ctrl_chk.sv
module sercmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       par_en,
  input logic       tx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_par,
  input logic       out_drive
);
  p_float_when_deselected_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> (!out_drive && !tx_valid));

  p_silent_when_floated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_drive |-> !tx_valid);

  p_mute_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !out_drive) |=> (!cs || !out_drive));

  p_hold_until_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (!cs || (tx_valid && $stable(tx_data))));

  p_even_parity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && par_en) |-> ($countones({tx_data, tx_par}) % 2 == 0));

  p_no_parity_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !par_en) |-> !tx_par);
endmodule

bind sercmd_ctrl sercmd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .par_en(par_en), .tx_ready(tx_ready),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_par(tx_par), .out_drive(out_drive)
);

// File: tb/sercmd_ctrl_bench.sv
`timescale 1ns/1ps
module sercmd_ctrl_bench;
  localparam int BUSY = 40;
  localparam int LASTA = 511;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, par_en = 1'b0;
  logic rx_valid = 1'b0, rx_perr = 1'b0, tx_ready = 1'b0;
  logic [7:0] rx_data = '0;
  logic tx_valid, tx_par, out_drive;
  logic [7:0] tx_data;

  sercmd_ctrl #(.ADDR_W(9), .BUSY_CYC(BUSY)) u_sercmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cs(cs), .par_en(par_en), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_perr(rx_perr), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_par(tx_par), .out_drive(out_drive)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit fin = 0;
  logic [7:0] mmem [512];
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] last_rx = '0;
  int m_state = 0;
  bit m_perr = 0, m_ierr = 0, m_wr = 0, wr_seen = 0;
  logic [7:0] m_hi = '0;
  int m_addr = 0;
  realtime wr_t = 0;
  logic [7:0] lf = 8'h5B;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_busy();
    real e;
    if (!wr_seen) return 0;
    e = ($realtime - wr_t) / 5.0;
    return (e >= 0.5) && (e <= BUSY + 0.5);
  endfunction

  always @(posedge clk) begin
    #1;
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    tx_ready = lf[0] | lf[3];
  end

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      chk(out_drive === (cs && m_state != 5), "R1/R5/R7 drive", out_drive, cs && m_state != 5);
      if (!out_drive) chk(tx_valid === 1'b0, "R5/R7 silent", tx_valid, 0);
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, "R4 unexpected byte", tx_data, 0);
        end else begin
          chk(tx_data === exp_q[0], tag_q[0], tx_data, exp_q[0]);
          chk(tx_par === (par_en ? ^tx_data : 1'b0), "R6 parity", tx_par, par_en ? ^tx_data : 1'b0);
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
          if (exp_q.size() == 0 && m_state == 4) m_state = 0;
        end
        last_rx = tx_data;
      end
    end
  end

  task automatic model_rx(input logic [7:0] d, input bit pe);
    case (m_state)
      0: begin
        if (pe) begin m_perr = 1; m_state = 5; end
        else if (d == 8'h3C) begin
          exp_q.push_back({3'b101, m_perr, m_ierr, m_busy(), 2'b00});
          tag_q.push_back("R2 status");
          m_perr = 0; m_ierr = 0; m_state = 4;
        end else if (m_busy()) m_state = 0;
        else if (d == 8'hA3) begin m_wr = 0; m_state = 1; end
        else if (d == 8'h5A) begin m_wr = 1; m_state = 1; end
        else begin m_ierr = 1; m_state = 5; end
      end
      1: if (pe) begin m_perr = 1; m_state = 5; end else begin m_hi = d; m_state = 2; end
      2: if (pe) begin m_perr = 1; m_state = 5; end
         else begin
           m_addr = {m_hi, d} & 16'h01FF;
           if (m_wr) m_state = 3;
           else begin
             for (int a = m_addr; a <= LASTA; a++) begin
               exp_q.push_back(mmem[a]);
               tag_q.push_back("R3/R4 stream");
             end
             m_state = 4;
           end
         end
      3: if (pe) begin m_perr = 1; m_state = 5; end
         else begin mmem[m_addr] = d; wr_t = $realtime; wr_seen = 1; m_state = 0; end
      default: ;
    endcase
  endtask

  task automatic send_byte(input logic [7:0] d, input bit pe = 0);
    @(posedge clk); #1;
    rx_valid = 1; rx_data = d; rx_perr = pe;
    @(posedge clk);
    model_rx(d, pe);
    #1 rx_valid = 0; rx_perr = 0;
  endtask

  task automatic set_cs(input logic v);
    @(posedge clk); #1;
    cs = v;
    if (!v) begin
      m_state = 0;
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  task automatic cs_pulse();
    set_cs(0);
    repeat (3) @(posedge clk);
    set_cs(1);
  endtask

  task automatic wait_drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 5000) begin @(posedge clk); n++; end
    repeat (6) @(posedge clk);
    chk(exp_q.size() == 0, "R3/R4 all bytes delivered", exp_q.size(), 0);
  endtask

  task automatic stat_expect(input logic [7:0] v, input string tag);
    send_byte(8'h3C);
    wait_drain();
    chk(last_rx == v, tag, last_rx, v);
  endtask

  task automatic write_loc(input int a, input logic [7:0] d);
    send_byte(8'h5A);
    send_byte(8'(a >> 8));
    send_byte(8'(a));
    send_byte(d);
  endtask

  task automatic rseq(input int a);
    send_byte(8'hA3);
    send_byte(8'(a >> 8));
    send_byte(8'(a));
  endtask

  initial begin
    #(200000 * 5);
    if (!fin) begin
      fin = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    chk(out_drive === 0 && tx_valid === 0, "R1 reset deselected", {out_drive, tx_valid}, 0);
    set_cs(1);
    repeat (3) @(posedge clk);
    #1 chk(out_drive === 1 && tx_valid === 0, "R1 idle selected", {out_drive, tx_valid}, 2);

    stat_expect(8'hA0, "R2 idle status");

    // R10: write then status during busy
    write_loc(500, 8'h11);
    stat_expect(8'hA4, "R10 busy status");
    repeat (BUSY + 5) @(posedge clk);
    stat_expect(8'hA0, "R10 after busy");

    for (int a = 501; a <= LASTA; a++) begin
      write_loc(a, 8'(a * 7 + 3));
      repeat (BUSY + 3) @(posedge clk);
    end

    // R11: opcode during busy is dropped
    write_loc(499, 8'hC5);
    send_byte(8'hA3);
    send_byte(8'h77);
    repeat (BUSY + 5) @(posedge clk);
    stat_expect(8'hA0, "R11 dropped during busy");

    // R3, R6: stream with parity
    par_en = 1;
    rseq(505);
    wait_drain();
    chk(last_rx == mmem[LASTA], "R4 last byte is top address", last_rx, mmem[LASTA]);

    // R4: longer stream, no parity
    par_en = 0;
    rseq(16'hFE00 | 499);
    wait_drain();
    chk(tx_valid === 0, "R4 no wrap", tx_valid, 0);

    // R5: chip select drop mid stream
    par_en = 1;
    rseq(500);
    while (exp_q.size() > 9) @(posedge clk);
    set_cs(0);
    repeat (4) @(posedge clk);
    set_cs(1);
    repeat (20) @(posedge clk);
    #1 chk(tx_valid === 0, "R5 stream ended", tx_valid, 0);
    stat_expect(8'hA0, "R5 clean after drop");

    // R7, R9: unknown opcode, ignored input while muted
    send_byte(8'h77);
    send_byte(8'h3C);
    send_byte(8'h3C, 1);
    repeat (10) @(posedge clk);
    #1 chk(out_drive === 0 && tx_valid === 0, "R7 muted", {out_drive, tx_valid}, 0);
    cs_pulse();
    stat_expect(8'hA8, "R9 instr flag survives");
    stat_expect(8'hA0, "R9 flag cleared");

    // R8: parity failure on opcode
    send_byte(8'h3C, 1);
    repeat (5) @(posedge clk);
    cs_pulse();
    stat_expect(8'hB0, "R8 parity flag");
    stat_expect(8'hA0, "R9 parity flag cleared");

    // R8: parity failure on data byte, no write
    send_byte(8'h5A);
    send_byte(8'h01);
    send_byte(8'hFF);
    send_byte(8'h99, 1);
    cs_pulse();
    stat_expect(8'hB0, "R8 data parity flag");
    rseq(511);
    wait_drain();
    chk(last_rx == mmem[LASTA], "R8 data not written", last_rx, mmem[LASTA]);

    fin = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule